// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry-Out

This block forms the second operand of a processor datapath by shifting or rotating a data word by a byte-wide amount, and at the same time produces the next value of the carry flag. Three operations are offered: logical left shift, logical right shift and rotate right. A fourth code passes the word through untouched. The carry follows strict per-amount rules. A zero amount never changes it. A shift by exactly the word width still yields a shifted-out bit, while a shift beyond the width clears it. Rotates of the word width or more wrap around.

Operands arrive on a valid/ready stream and results leave on a second one. A transfer happens on a rising clock edge where valid and ready are both high. With the default `OUT_REG = 1`, one result register sits at the output. A result therefore appears the cycle after its operand is accepted. While the consumer holds `out_ready` low, the result register keeps its contents and refuses new operands (`in_ready` low), so no result is lost or overwritten. With `OUT_REG = 0` the unit is purely combinational, and the handshake passes straight through. The word width `W` must be a power of two.

Top module: `shf_carry_shifter`

## Requirements
- R1: With op code 2'b00 (left shift) and amount n in 1..W-1, the result is the operand shifted up by n with zeros in the low n bits, and the carry becomes operand bit[W-n].
- R2: With op code 2'b01 (right shift) and amount n in 1..W-1, the result is the operand shifted down by n with zeros in the top n bits, and the carry becomes operand bit[n-1].
- R3: An amount of 0 with any op code passes the operand through unchanged and keeps the incoming carry.
- R4: A left or right shift by exactly W gives an all-zero result, with carry operand bit[0] for left and operand bit[W-1] for right.
- R5: A left or right shift by more than W gives an all-zero result and, when the flag update is enabled, a carry of 0.
- R6: With op code 2'b10 (rotate right) and amount n in 1..W-1, the low n operand bits move to the top of the result, the rest move down by n, and the carry becomes operand bit[n-1], which is the result's top bit.
- R7: A rotate by a nonzero multiple of W returns the operand with carry operand bit[W-1]; any rotate amount above W acts like that amount minus W.
- R8: When the flag-update input is low, the carry output equals the carry input for every op code and amount.
- R9: Op code 2'b11 passes the operand through unchanged and keeps the incoming carry.
- R10: With OUT_REG = 1, an accepted operand's result is presented on the next cycle. While out_valid is high and out_ready low, out_data and out_carry hold and in_ready is low.
- R11: While reset is asserted, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_data | input | W | Word to shift or rotate |
| in_amt | input | AW | Shift or rotate amount |
| in_op | input | 2 | 00 left shift, 01 right shift, 10 rotate right, 11 pass |
| in_cin | input | 1 | Current carry flag |
| in_upd | input | 1 | Carry flag update enable |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | W | Shifted or rotated word |
| out_carry | output | 1 | Next carry flag value |

## Verification
The bench aims at the amount boundaries 0, 1, W-1, W, W+1, 2W-1, 2W and 255 for each op code. A unit that treats W like W+1 would clear the carry instead of returning bit[0] or bit[W-1]. One that reduces rotates modulo 2W instead of W would scramble a rotate by 63. A zero amount that still updates the carry would corrupt the flag on a plain move. The flag-update-off case and the reserved op code catch a carry that leaks through the shift path. A held result stream catches a register that is overwritten while the consumer stalls.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL  = 2'b00,
    SHF_LSR  = 2'b01,
    SHF_ROR  = 2'b10,
    SHF_PASS = 2'b11
  } shf_op_e;
endpackage

// File: rtl/shf_amt_decode.sv
// Classifies the raw amount against the word width.
module shf_amt_decode #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int SW = $clog2(W)
) (
  input  logic [AW-1:0] amt,
  output logic          is_zero,
  output logic          ge_w,
  output logic          gt_w,
  output logic [SW-1:0] low_amt
);
  always_comb begin
    is_zero = (amt == '0);
    ge_w    = (amt >= AW'(W));
    gt_w    = (amt >  AW'(W));
    low_amt = amt[SW-1:0];
  end
endmodule

// File: rtl/shf_rotator.sv
// Log-depth right rotator: stage k rotates by 2**k when sel[k] is set.
module shf_rotator #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [SW+1];
  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stage[k+1] = sel[k] ? {stage[k][S-1:0], stage[k][W-1:S]} : stage[k];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/shf_out_stage.sv
// Optional one-entry result register with valid/ready handshake.
module shf_out_stage #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_carry
);
  if (OUT_REG) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;
    logic         carry_q;

    assign in_ready = !full_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q  <= 1'b0;
        data_q  <= '0;
        carry_q <= 1'b0;
      end else if (in_valid && in_ready) begin
        full_q  <= 1'b1;
        data_q  <= in_data;
        carry_q <= in_carry;
      end else if (out_ready) begin
        full_q  <= 1'b0;
      end
    end

    assign out_valid = full_q;
    assign out_data  = data_q;
    assign out_carry = carry_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
    assign out_carry = in_carry;
  end
endmodule

// File: rtl/shf_carry_shifter.sv
module shf_carry_shifter #(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic [AW-1:0] in_amt,
  input  logic [1:0]    in_op,
  input  logic          in_cin,
  input  logic          in_upd,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_carry
);
  import shf_pkg::*;
  localparam int SW = $clog2(W);

  shf_op_e      op;
  logic         amt_zero, amt_ge, amt_gt;
  logic [SW-1:0] amt_low, rot_sel;
  logic [W-1:0] rot_out, mask_lo, mask_hi;
  logic [W-1:0] res;
  logic         new_c, carry_nxt;

  assign op = shf_op_e'(in_op);

  shf_amt_decode #(.W(W), .AW(AW)) u_dec (
    .amt     (in_amt),
    .is_zero (amt_zero),
    .ge_w    (amt_ge),
    .gt_w    (amt_gt),
    .low_amt (amt_low)
  );

  // A left rotate by r equals a right rotate by (W - r) mod W.
  assign rot_sel = (op == SHF_LSL) ? SW'(~amt_low + 1'b1) : amt_low;

  shf_rotator #(.W(W)) u_rot (
    .din  (in_data),
    .sel  (rot_sel),
    .dout (rot_out)
  );

  assign mask_lo = {W{1'b1}} >> amt_low;  // keeps bits a right shift retains
  assign mask_hi = {W{1'b1}} << amt_low;  // keeps bits a left shift retains

  always_comb begin
    res   = in_data;
    new_c = in_cin;
    if (!amt_zero) begin
      unique case (op)
        SHF_LSL: begin
          res   = amt_ge ? '0 : (rot_out & mask_hi);
          new_c = amt_gt ? 1'b0 : rot_out[0];
        end
        SHF_LSR: begin
          res   = amt_ge ? '0 : (rot_out & mask_lo);
          new_c = amt_gt ? 1'b0 : rot_out[W-1];
        end
        SHF_ROR: begin
          res   = rot_out;
          new_c = rot_out[W-1];
        end
        default: begin
          res   = in_data;
          new_c = in_cin;
        end
      endcase
    end
    carry_nxt = in_upd ? new_c : in_cin;
  end

  shf_out_stage #(.W(W), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res),
    .in_carry  (carry_nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_carry (out_carry)
  );
endmodule

// File: rtl/shf_carry_shifter_chk.sv
module shf_carry_shifter_chk #(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic [AW-1:0] in_amt,
  input logic [1:0]    in_op,
  input logic          in_cin,
  input logic          in_upd,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          out_carry
);
  logic acc, is_shift;
  assign acc      = in_valid && in_ready;
  assign is_shift = (in_op == 2'b00) || (in_op == 2'b01);

  assert_idle_in_reset_R11: assert property (@(posedge clk) !rst_n |=> !out_valid);

  if (OUT_REG) begin : g_reg
    assert_keep_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_upd) |=> (out_carry == $past(in_cin)));
    assert_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_amt == '0) |=> (out_data == $past(in_data) && out_carry == $past(in_cin)));
    assert_wide_shift_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_shift && in_amt >= AW'(W)) |=> (out_data == '0));
    assert_over_shift_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_shift && in_amt > AW'(W) && in_upd) |=> !out_carry);
    assert_rot_carry_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op == 2'b10 && in_amt != '0 && in_upd) |=> (out_carry == out_data[W-1]));
    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_carry)));
    assert_block_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end else begin : g_pass
    assert_keep_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_upd) |-> (out_carry == in_cin));
    assert_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_amt == '0) |-> (out_data == in_data && out_carry == in_cin));
    assert_wide_shift_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_shift && in_amt >= AW'(W)) |-> (out_data == '0));
    assert_rot_carry_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b10 && in_amt != '0 && in_upd) |-> (out_carry == out_data[W-1]));
    assert_ready_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == out_ready && out_valid == in_valid);
  end
endmodule

bind shf_carry_shifter shf_carry_shifter_chk #(.W(W), .AW(AW), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_amt(in_amt), .in_op(in_op), .in_cin(in_cin),
  .in_upd(in_upd), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_carry(out_carry)
);

// File: tb/shf_carry_shifter_tb.sv
module shf_carry_shifter_tb;
  localparam int W = 32;
  localparam int AW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_data = '0;
  logic [AW-1:0] in_amt = '0;
  logic [1:0] in_op = 2'b00;
  logic in_cin = 1'b0, in_upd = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic out_carry;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_carry_shifter #(.W(W), .AW(AW), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_amt(in_amt), .in_op(in_op), .in_cin(in_cin),
    .in_upd(in_upd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_carry(out_carry)
  );

  // Behavioural model written per bit from the requirements.
  function automatic logic [W:0] ref_model(input logic [1:0] op, input int n,
                                           input logic [W-1:0] a, input logic ci,
                                           input logic upd);
    logic [W-1:0] r;
    logic c;
    int m;
    r = a; c = ci;
    if (n != 0 && op != 2'b11) begin
      if (op == 2'b00) begin
        for (int i = 0; i < W; i++) r[i] = (i >= n) ? a[i-n] : 1'b0;
        c = (n <= W) ? a[W-n] : 1'b0;
      end else if (op == 2'b01) begin
        for (int i = 0; i < W; i++) r[i] = (i + n < W) ? a[i+n] : 1'b0;
        c = (n <= W) ? a[n-1] : 1'b0;
      end else begin
        m = n;
        while (m > W) m = m - W;
        for (int i = 0; i < W; i++) r[i] = a[(i + m) % W];
        c = a[m-1];
      end
    end
    if (!upd) c = ci;
    return {c, r};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual carry=%0b data=%h expected carry=%0b data=%h",
               req, act[W], act[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  // Send one operand with out_ready high and check the registered result.
  task automatic run_one(input string req, input logic [1:0] op, input int n,
                         input logic [W-1:0] a, input logic ci, input logic upd);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_amt = AW'(n); in_data = a; in_cin = ci; in_upd = upd;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {W'(0), out_valid}, {W'(0), 1'b1});
    check(req, {out_carry, out_data}, ref_model(op, n, a, ci, upd));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 reset", {W'(0), out_valid}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_lsl();
    run_one("R1 lsl 1", 2'b00, 1, 32'h8000_0001, 1'b0, 1'b1);
    run_one("R1 lsl 31", 2'b00, 31, 32'h0000_0003, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) run_one("R1 lsl rnd", 2'b00, 1 + i * 5, $urandom, 1'b1, 1'b1);
  endtask

  task automatic t_lsr();
    run_one("R2 lsr 1", 2'b01, 1, 32'h0000_0001, 1'b0, 1'b1);
    run_one("R2 lsr 31", 2'b01, 31, 32'hC000_0000, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) run_one("R2 lsr rnd", 2'b01, 2 + i * 5, $urandom, 1'b0, 1'b1);
  endtask

  task automatic t_zero();
    for (int op = 0; op < 4; op++) begin
      run_one("R3 zero c1", 2'(op), 0, $urandom, 1'b1, 1'b1);
      run_one("R3 zero c0", 2'(op), 0, $urandom, 1'b0, 1'b1);
    end
  endtask

  task automatic t_width();
    run_one("R4 lsl 32 b0", 2'b00, 32, 32'h0000_0001, 1'b0, 1'b1);
    run_one("R4 lsl 32 b0 clr", 2'b00, 32, 32'hFFFF_FFFE, 1'b1, 1'b1);
    run_one("R4 lsr 32 b31", 2'b01, 32, 32'h8000_0000, 1'b0, 1'b1);
    run_one("R4 lsr 32 b31 clr", 2'b01, 32, 32'h7FFF_FFFF, 1'b1, 1'b1);
  endtask

  task automatic t_over();
    int amts[4] = '{33, 63, 64, 255};
    foreach (amts[i]) begin
      run_one("R5 lsl over", 2'b00, amts[i], 32'hFFFF_FFFF, 1'b1, 1'b1);
      run_one("R5 lsr over", 2'b01, amts[i], 32'hFFFF_FFFF, 1'b1, 1'b1);
    end
  endtask

  task automatic t_ror();
    run_one("R6 ror 1", 2'b10, 1, 32'h0000_0001, 1'b0, 1'b1);
    run_one("R6 ror 31", 2'b10, 31, 32'h4000_0000, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) run_one("R6 ror rnd", 2'b10, 3 + i * 5, $urandom, 1'b0, 1'b1);
  endtask

  task automatic t_ror_wrap();
    run_one("R7 ror 32", 2'b10, 32, 32'h8000_0000, 1'b0, 1'b1);
    run_one("R7 ror 33", 2'b10, 33, 32'h0000_0001, 1'b0, 1'b1);
    run_one("R7 ror 63", 2'b10, 63, 32'h4000_0000, 1'b0, 1'b1);
    run_one("R7 ror 64", 2'b10, 64, 32'h7FFF_FFFF, 1'b1, 1'b1);
    run_one("R7 ror 255", 2'b10, 255, 32'h4000_0001, 1'b0, 1'b1);
  endtask

  task automatic t_noupd();
    int amts[8] = '{0, 1, 31, 32, 33, 63, 64, 255};
    for (int op = 0; op < 3; op++)
      foreach (amts[i]) begin
        run_one("R8 no update c1", 2'(op), amts[i], 32'hFFFF_FFFF, 1'b1, 1'b0);
        run_one("R8 no update c0", 2'(op), amts[i], 32'hFFFF_FFFF, 1'b0, 1'b0);
      end
  endtask

  task automatic t_pass();
    run_one("R9 pass 5", 2'b11, 5, 32'h1234_5678, 1'b1, 1'b1);
    run_one("R9 pass 40", 2'b11, 40, 32'hDEAD_BEEF, 1'b0, 1'b1);
  endtask

  task automatic t_stall();
    logic [W:0] first, second;
    first  = ref_model(2'b10, 4, 32'hA5A5_0F0F, 1'b0, 1'b1);
    second = ref_model(2'b00, 8, 32'h0102_0304, 1'b0, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b10; in_amt = 8'd4; in_data = 32'hA5A5_0F0F; in_cin = 1'b0; in_upd = 1'b1;
    @(negedge clk);
    in_op = 2'b00; in_amt = 8'd8; in_data = 32'h0102_0304;
    check("R10 stall ready low", {W'(0), in_ready}, '0);
    repeat (3) @(negedge clk);
    check("R10 stall hold", {out_carry, out_data}, first);
    check("R10 stall valid", {W'(0), out_valid}, {W'(0), 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 release", {out_carry, out_data}, second);
    @(negedge clk);
    check("R10 drained", {W'(0), out_valid}, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_lsl();
    t_lsr();
    t_zero();
    t_width();
    t_over();
    t_ror();
    t_ror_wrap();
    t_noupd();
    t_pass();
    t_stall();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule